// File: doc/BRIEF.md
# Streaming Dark-Valley Line Detector

This block inspects one colour channel of a line-scan image while the pixels stream in. For every incoming pixel it looks at the 24 most recent pixels of the current line. It checks whether they hold a narrow dark valley: a steep fall near the start, a dark floor in the middle and a steep rise near the end. A line that contains such a valley is counted at most once. The per-image count is kept with saturation. When the image closes, a reject decision is latched if the count is above a fixed limit.

A 4-bit sensitivity selector sets the darkness threshold for the floor test, so each camera can be trimmed for its own lighting. Each pixel is fully judged on the clock edge that accepts it. Nothing is left to do after the end-of-image strobe except latch the decision. The strobes (image start, line start, image end) are single-cycle pulses that never coincide with a valid pixel.

A small state machine sequences the work. It has three states:

- `ST_IDLE`: outside any image.
- `ST_SEARCH`: inside an image, and the current line has not hit yet.
- `ST_HIT`: the current line has already been counted.

Its transitions are:

- **image start:** every state goes to `ST_SEARCH`.
- **image end:** `ST_SEARCH` or `ST_HIT` goes to `ST_IDLE`.
- **line start:** `ST_SEARCH` or `ST_HIT` goes to `ST_SEARCH`.
- **qualifying pixel:** `ST_SEARCH` goes to `ST_HIT`.
- **otherwise:** the state holds.

When strobes compete, image start wins over image end, which wins over line start.

Top module: `valley_detector`

## Requirements
- R1: No valley is recognised in a line until the pixel being accepted is at least the 24th valid pixel since the last line start (or image start).
- R2: The fall test passes when, for some window position i in 0..3 (0 = oldest of the 24, 23 = the pixel being accepted), pixel i exceeds pixel i+6 by 16 or more.
- R3: The floor test passes when at least three of window positions 10..14 are strictly below the darkness threshold.
- R4: The rise test passes when, for some window position j in 14..17, pixel j+6 exceeds pixel j by 15 or more.
- R5: The darkness threshold equals 60 + 2 × `sens_sel`, giving 60..90.
- R6: At most one hit is counted per line; a line start re-arms counting and restarts the 24-pixel fill.
- R7: An image start clears the occurrence count and the reject output in the next cycle.
- R8: On image end inside an image, `reject` becomes 1 when the count is greater than 10, otherwise 0; it then holds until the next image start.
- R9: The occurrence count saturates at 63 instead of wrapping.
- R10: Outside an image (after image end, before image start), pixels, line starts and image ends change neither the count nor `reject`.
- R11: A qualifying pixel raises the count by exactly one, visible right after the clock edge that accepts that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | A channel pixel is present on `pix_data` |
| pix_data | input | 8 | Pixel intensity |
| line_start | input | 1 | Pulse before the first pixel of a line |
| image_start | input | 1 | Pulse opening an image |
| image_end | input | 1 | Pulse closing an image |
| sens_sel | input | 4 | Darkness threshold selector |
| occ_count | output | 6 | Lines with a valley in the current image |
| reject | output | 1 | Latched reject decision of the last image |

## Verification
A wrong state shows first on `occ_count`. If the line-hit state were lost, a second valley in the same line would add a count on the very pixel that completes it. A stuck idle state freezes the count for a whole image, and a stale fill counter produces a count on a pixel fewer than 24 into a line. Each stage of the test (fall, floor, rise, threshold) is varied on its own by one intensity level around its limit, so an off-by-one compare shows as a missing or extra count on the 24th pixel of that line. Errors in the decision path show on `reject` one cycle after image end, and as a change of `reject` while no image is open.

// File: rtl/vd_pkg.sv
package vd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_HIT    = 2'd2
    } vd_state_e;

endpackage

// File: rtl/vd_window.sv
module vd_window #(
    parameter int PIX_W = 8,
    parameter int WIN   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             restart,
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W-1:0] win [WIN],
    output logic             full
);
    localparam int HIST   = WIN - 1;
    localparam int FILL_W = $clog2(WIN);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST);

    logic [PIX_W-1:0]  hist [HIST];
    logic [FILL_W-1:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (restart) begin
            fill <= '0;
        end else if (shift_en && fill != FILL_MAX) begin
            fill <= fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (shift_en) begin
            hist[0] <= pix;
            for (int k = 1; k < HIST; k++) begin
                hist[k] <= hist[k-1];
            end
        end
    end

    generate
        for (genvar k = 0; k < WIN; k++) begin : g_win
            if (k == WIN - 1) begin : g_live
                assign win[k] = pix;
            end else begin : g_hist
                assign win[k] = hist[WIN-2-k];
            end
        end
    endgenerate

    assign full = (fill == FILL_MAX);

endmodule

// File: rtl/vd_match.sv
module vd_match #(
    parameter int PIX_W     = 8,
    parameter int WIN       = 24,
    parameter int GAP       = 6,
    parameter int EDGE_SPAN = 10,
    parameter int FLOOR_LO  = 10,
    parameter int FLOOR_HI  = 14,
    parameter int MIN_DARK  = 3,
    parameter int FALL_MIN  = 16,
    parameter int RISE_MIN  = 15
) (
    input  logic [PIX_W-1:0] win [WIN],
    input  logic [PIX_W-1:0] thr,
    output logic             valley
);
    localparam int FALL_LAST  = EDGE_SPAN - 1 - GAP;
    localparam int RISE_FIRST = WIN - EDGE_SPAN;
    localparam int RISE_LAST  = WIN - 1 - GAP;

    logic fall_ok, floor_ok, rise_ok;
    int   dark_n;

    always_comb begin
        fall_ok = 1'b0;
        for (int i = 0; i <= FALL_LAST; i++) begin
            if (int'(win[i]) - int'(win[i+GAP]) >= FALL_MIN) fall_ok = 1'b1;
        end
    end

    always_comb begin
        dark_n = 0;
        for (int i = FLOOR_LO; i <= FLOOR_HI; i++) begin
            if (win[i] < thr) dark_n = dark_n + 1;
        end
        floor_ok = (dark_n >= MIN_DARK);
    end

    always_comb begin
        rise_ok = 1'b0;
        for (int j = RISE_FIRST; j <= RISE_LAST; j++) begin
            if (int'(win[j+GAP]) - int'(win[j]) >= RISE_MIN) rise_ok = 1'b1;
        end
    end

    assign valley = fall_ok && floor_ok && rise_ok;

endmodule

// File: rtl/vd_tally.sv
module vd_tally #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/valley_detector.sv
module valley_detector #(
    parameter int PIX_W    = 8,
    parameter int WIN      = 24,
    parameter int SEL_W    = 4,
    parameter int THR_BASE = 60,
    parameter int THR_STEP = 2,
    parameter int CNT_W    = 6,
    parameter int LIMIT    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             line_start,
    input  logic             image_start,
    input  logic             image_end,
    input  logic [SEL_W-1:0] sens_sel,
    output logic [CNT_W-1:0] occ_count,
    output logic             reject
);
    import vd_pkg::*;

    vd_state_e        state, state_nx;
    logic [PIX_W-1:0] win [WIN];
    logic [PIX_W-1:0] thr;
    logic             full, valley, active, take_hit, restart;

    assign active   = (state != ST_IDLE);
    assign thr      = PIX_W'(THR_BASE + THR_STEP * int'(sens_sel));
    assign restart  = image_start || (active && line_start);
    assign take_hit = (state == ST_SEARCH) && pix_valid && full && valley
                      && !image_start && !image_end && !line_start;

    vd_window #(.PIX_W(PIX_W), .WIN(WIN)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pix_valid && active),
        .restart  (restart),
        .pix      (pix_data),
        .win      (win),
        .full     (full)
    );

    vd_match #(.PIX_W(PIX_W), .WIN(WIN)) u_match (
        .win    (win),
        .thr    (thr),
        .valley (valley)
    );

    vd_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (image_start),
        .inc   (take_hit),
        .cnt   (occ_count)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (image_start) state_nx = ST_SEARCH;
            end
            ST_SEARCH: begin
                if (image_start)     state_nx = ST_SEARCH;
                else if (image_end)  state_nx = ST_IDLE;
                else if (line_start) state_nx = ST_SEARCH;
                else if (take_hit)   state_nx = ST_HIT;
            end
            ST_HIT: begin
                if (image_start)     state_nx = ST_SEARCH;
                else if (image_end)  state_nx = ST_IDLE;
                else if (line_start) state_nx = ST_SEARCH;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reject <= 1'b0;
        end else if (image_start) begin
            reject <= 1'b0;
        end else if (image_end && active) begin
            reject <= (occ_count > CNT_W'(LIMIT));
        end
    end

endmodule

// File: rtl/vd_checker.sv
module vd_checker #(
    parameter int CNT_W = 6,
    parameter int LIMIT = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               image_start,
    input logic               image_end,
    input vd_pkg::vd_state_e  state,
    input logic [CNT_W-1:0]   occ_count,
    input logic               reject
);
    import vd_pkg::*;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        image_start |=> (occ_count == '0 && !reject));

    a_r6_one_per_line: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIT && !image_start) |=> $stable(occ_count));

    a_r8_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (image_end && !image_start && state != ST_IDLE)
        |=> (reject == ($past(occ_count) > CNT_W'(LIMIT))));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!image_start && !(image_end && state != ST_IDLE)) |=> $stable(reject));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !image_start) |=> $stable(occ_count));

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_count == CNT_MAX && !image_start) |=> (occ_count == CNT_MAX));

    a_r11_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!image_start && occ_count != CNT_MAX)
        |=> (occ_count == $past(occ_count) || occ_count == $past(occ_count) + 1'b1));

endmodule

bind valley_detector vd_checker #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .image_start (image_start),
    .image_end   (image_end),
    .state       (state),
    .occ_count   (occ_count),
    .reject      (reject)
);

// File: tb/valley_detector_bench.sv
`timescale 1ns/1ps
module valley_detector_bench;

    typedef struct packed {
        logic [7:0] fall;
        logic [7:0] floorv;
        logic [2:0] ndark;
        logic [7:0] rise;
        logic [3:0] sel;
        logic       hit;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{8'd16,  8'd50, 3'd3, 8'd15,  4'd0,  1'b1},
        '{8'd15,  8'd50, 3'd3, 8'd15,  4'd0,  1'b0},
        '{8'd16,  8'd50, 3'd3, 8'd14,  4'd0,  1'b0},
        '{8'd16,  8'd50, 3'd2, 8'd15,  4'd0,  1'b0},
        '{8'd16,  8'd60, 3'd3, 8'd15,  4'd0,  1'b0},
        '{8'd16,  8'd60, 3'd3, 8'd15,  4'd1,  1'b1},
        '{8'd16,  8'd89, 3'd3, 8'd15,  4'd15, 1'b1},
        '{8'd16,  8'd90, 3'd3, 8'd15,  4'd15, 1'b0},
        '{8'd200, 8'd0,  3'd4, 8'd155, 4'd7,  1'b1},
        '{8'd30,  8'd75, 3'd3, 8'd40,  4'd8,  1'b1},
        '{8'd30,  8'd76, 3'd3, 8'd40,  4'd8,  1'b0},
        '{8'd16,  8'd59, 3'd3, 8'd15,  4'd0,  1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_valid, line_start, image_start, image_end;
    logic [7:0] pix_data;
    logic [3:0] sens_sel;
    logic [5:0] occ_count;
    logic       reject;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    valley_detector u_valley_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .pix_data    (pix_data),
        .line_start  (line_start),
        .image_start (image_start),
        .image_end   (image_end),
        .sens_sel    (sens_sel),
        .occ_count   (occ_count),
        .reject      (reject)
    );

    function automatic logic [7:0] pat_px(int k, vec_t v);
        if (k < 6)       return 8'd200;
        else if (k < 10) return 8'd200 - v.fall;
        else if (k < 14) return ((k - 10) < int'(v.ndark)) ? v.floorv : 8'd200;
        else if (k < 20) return 8'd100;
        else             return 8'd100 + v.rise;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_px(logic [7:0] d);
        pix_valid = 1'b1;
        pix_data  = d;
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic send_line(vec_t v, int from, int upto);
        for (int k = from; k < upto; k++) send_px(pat_px(k, v));
    endtask

    task automatic p_soi();
        image_start = 1'b1; @(negedge clk); image_start = 1'b0;
    endtask

    task automatic p_sol();
        line_start = 1'b1; @(negedge clk); line_start = 1'b0;
    endtask

    task automatic p_eoi();
        image_end = 1'b1; @(negedge clk); image_end = 1'b0;
    endtask

    task automatic hit_lines(int n);
        for (int l = 0; l < n; l++) begin
            p_sol();
            send_line(TBL[0], 0, 24);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pix_valid = 1'b0; pix_data = '0; line_start = 1'b0;
        image_start = 1'b0; image_end = 1'b0; sens_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset count", int'(occ_count), 0);
        chk("R8 reset reject", int'(reject), 0);

        // Table walk: one line per vector, fall/floor/rise/threshold limits
        for (int n = 0; n < NV; n++) begin
            p_soi();
            sens_sel = TBL[n].sel;
            p_sol();
            send_line(TBL[n], 0, 23);
            chk("R1 no hit before 24th pixel", int'(occ_count), 0);
            send_line(TBL[n], 23, 24);
            // R2 R3 R4 R5 decide the hit; R11 count visible right after the pixel edge
            chk($sformatf("R2/R3/R4/R5/R11 vector %0d", n), int'(occ_count), int'(TBL[n].hit));
            p_eoi();
            chk("R8 reject low for small count", int'(reject), 0);
        end

        // R6: two valleys in one line count once; line start re-arms
        sens_sel = 4'd0;
        p_soi();
        p_sol();
        send_line(TBL[0], 0, 24);
        send_line(TBL[0], 0, 24);
        chk("R6 one hit per line", int'(occ_count), 1);
        hit_lines(1);
        chk("R6 re-armed by line start", int'(occ_count), 2);

        // R1: a short line (23 pixels) after line start never counts
        p_sol();
        send_line(TBL[0], 1, 24);
        chk("R1 short line ignored", int'(occ_count), 2);

        // R8: exactly ten hits do not reject
        hit_lines(8);
        chk("R11 ten hits counted", int'(occ_count), 10);
        p_eoi();
        chk("R8 count of 10 keeps reject low", int'(reject), 0);

        // R7 / R8: eleven hits reject
        p_soi();
        chk("R7 image start clears count", int'(occ_count), 0);
        hit_lines(11);
        p_eoi();
        chk("R8 count of 11 rejects", int'(reject), 1);

        // R10: activity outside an image is ignored
        hit_lines(1);
        chk("R10 idle pixels not counted", int'(occ_count), 11);
        p_eoi();
        chk("R10 idle image end leaves reject", int'(reject), 1);
        chk("R8 reject holds after image", int'(reject), 1);

        p_soi();
        chk("R7 image start clears reject", int'(reject), 0);
        chk("R7 image start clears count again", int'(occ_count), 0);

        // R9: saturation
        hit_lines(70);
        chk("R9 count saturates", int'(occ_count), 63);
        p_eoi();
        chk("R8 reject after saturated image", int'(reject), 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule